// File: doc/BRIEF.md
# Branch Lookahead Unit

This block sits beside an instruction queue. It searches the pending entries for the oldest conditional branch, works out that branch's target address before the branch reaches the head, and sends a prefetch request for the target on its own address stream. When the branch reaches the head, the unit resolves it against one 4-bit field of a condition register that it owns. If the branch is taken, the redirect PC is ready in the same cycle, so a taken branch adds no bubble. If it is not taken, the prefetched target is simply discarded.

The condition register has eight 4-bit fields. Execution units write these fields one at a time through their own write enables, and each field can be marked as awaiting a writer. A branch whose field still has a pending writer waits at the head until that field is written. Branch-and-link updates a dedicated link register with the return address, so no general register is used for it.

The queue is given to the unit as a parallel snapshot, with entry 0 as the head (oldest). The queue owner pops the head in any cycle where `rs_valid` is high. The prefetch port follows valid/ready rules. `pf_valid` rises when a branch is captured. It then stays high, with `pf_addr` held steady, until `pf_ready` is seen high at a clock edge. The unit does not resolve a branch until its target request has been accepted, so back-pressure on the prefetch port stalls resolution.

Top module: `brl_unit`

## Requirements
- R1: The condition register has eight 4-bit fields. Field i appears at `cr_out[4i+3:4i]`. `cr_wr_en[i]` loads field i from `cr_wr_data[4i+3:4i]` at the next edge. Several fields may be written in the same cycle, and fields whose enable is low keep their value.
- R2: Within a field, bit 3 is negative, bit 2 is positive, bit 1 is zero and bit 0 is summary overflow. The branch test code selects a bit: 0 selects negative, 1 positive, 2 zero, 3 summary overflow. The branch is taken when the selected bit equals the branch's sense bit. So "branch on plus" (code 0, sense 0) is taken when the negative bit is clear.
- R3: Suppose the tracker is idle and a valid conditional branch is present in the queue. In the next cycle `pf_valid` is high, and `pf_addr` equals the branch PC plus its sign-extended word displacement shifted left by two.
- R4: While `pf_valid` is high and `pf_ready` is low, `pf_valid` stays high and `pf_addr` stays unchanged. Exactly one request is made per tracked branch.
- R5: `rs_valid` is high, combinationally, when all of the following hold: the head is the tracked conditional branch, its prefetch has been accepted, and its field has no pending writer. In that same cycle, `redirect_valid` equals the taken outcome and `redirect_pc` equals the tracked target.
- R6: `cr_claim[i]` marks field i as pending from the next edge. A write to field i clears the pending mark, unless field i is also claimed in the same cycle, in which case it stays pending. A branch on a pending field does not resolve.
- R7: A not-taken resolution gives `rs_valid` with `redirect_valid` low. The tracker is then free for the next branch.
- R8: A taken resolution whose head entry has its link bit set loads `lr_out` with the branch PC plus 4 at the next edge. Any other resolution, and any cycle without a resolution, leaves `lr_out` unchanged.
- R9: Only the lowest-indexed valid conditional branch is tracked. Later branches get no prefetch request until that branch has resolved.
- R10: After reset the condition register and link register are zero, no field is pending, and `pf_valid` and `rs_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| q_vld | input | QD | Queue entry valid, entry 0 is the head |
| q_br | input | QD | Entry is a conditional branch |
| q_lnk | input | QD | Branch also writes the link register |
| q_fld | input | QD*3 | Condition field selected by each entry |
| q_tst | input | QD*2 | Bit test code for each entry (R2) |
| q_sense | input | QD | Value the tested bit must have to take the branch |
| q_disp | input | QD*DW | Signed word displacement for each entry |
| q_pc | input | QD*AW | PC of each entry |
| cr_wr_en | input | NF | Per-field write enables |
| cr_wr_data | input | NF*4 | Per-field write data |
| cr_claim | input | NF | Mark a field as awaiting a writer |
| pf_valid | output | 1 | Target prefetch request valid |
| pf_ready | input | 1 | Prefetch request accepted |
| pf_addr | output | AW | Target prefetch address |
| rs_valid | output | 1 | Head branch resolves this cycle (queue pops) |
| rs_taken | output | 1 | Resolved branch is taken |
| redirect_valid | output | 1 | Fetch redirect request |
| redirect_pc | output | AW | Redirect target |
| lr_out | output | AW | Link register |
| cr_out | output | NF*4 | Condition register contents |

## Verification
A condition write, claim or link update shows on its output one edge after the cycle that drives it. The prefetch request appears one cycle after a branch is first seen by an idle tracker. Resolution is combinational, so it is valid in the cycle after the accepting edge, or in the same cycle as a queue shift that moves the tracked branch to the head. The bench drives inputs on the falling edge and samples either after the next rising edge or a short delay after its own drive. Each check is therefore placed in exactly the cycle these latencies give.

// File: rtl/brl_pkg.sv
package brl_pkg;
  localparam int FLD_W = 4;

  typedef enum logic [1:0] {
    TST_NEG  = 2'd0,
    TST_POS  = 2'd1,
    TST_ZERO = 2'd2,
    TST_SO   = 2'd3
  } tst_e;

  typedef enum logic [1:0] {
    LA_IDLE = 2'd0,
    LA_REQ  = 2'd1,
    LA_WAIT = 2'd2
  } la_e;

  // Pick the flag a branch tests; field layout is neg,pos,zero,so from MSB.
  function automatic logic tst_bit(input logic [FLD_W-1:0] f, input logic [1:0] code);
    case (tst_e'(code))
      TST_NEG:  return f[3];
      TST_POS:  return f[2];
      TST_ZERO: return f[1];
      default:  return f[0];
    endcase
  endfunction
endpackage

// File: rtl/brl_crfile.sv
module brl_crfile import brl_pkg::*; #(
  parameter int NF = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NF-1:0]       wr_en,
  input  logic [NF*FLD_W-1:0] wr_data,
  input  logic [NF-1:0]       claim,
  output logic [NF*FLD_W-1:0] cr,
  output logic [NF-1:0]       pend
);
  for (genvar i = 0; i < NF; i++) begin : g_fld
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cr[i*FLD_W +: FLD_W] <= '0;
        pend[i]              <= 1'b0;
      end else begin
        if (wr_en[i]) cr[i*FLD_W +: FLD_W] <= wr_data[i*FLD_W +: FLD_W];
        // a fresh claim outranks a write landing in the same cycle
        if (claim[i])      pend[i] <= 1'b1;
        else if (wr_en[i]) pend[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/brl_scan.sv
module brl_scan #(
  parameter int QD = 4,
  parameter int AW = 32,
  parameter int DW = 14
) (
  input  logic [QD-1:0]    q_vld,
  input  logic [QD-1:0]    q_br,
  input  logic [QD*DW-1:0] q_disp,
  input  logic [QD*AW-1:0] q_pc,
  output logic             hit,
  output logic [AW-1:0]    hit_pc,
  output logic [AW-1:0]    hit_tgt
);
  localparam int EXT = AW - DW - 2;

  logic [QD-1:0]   cand;
  logic [AW-1:0]   tgt [QD];

  for (genvar i = 0; i < QD; i++) begin : g_ent
    logic [DW-1:0] d;
    assign d       = q_disp[i*DW +: DW];
    assign cand[i] = q_vld[i] & q_br[i];
    assign tgt[i]  = q_pc[i*AW +: AW] + {{EXT{d[DW-1]}}, d, 2'b00};
  end

  // lowest index wins: walk from the tail so the head overrides
  always_comb begin
    hit     = 1'b0;
    hit_pc  = '0;
    hit_tgt = '0;
    for (int i = QD - 1; i >= 0; i--) begin
      if (cand[i]) begin
        hit     = 1'b1;
        hit_pc  = q_pc[i*AW +: AW];
        hit_tgt = tgt[i];
      end
    end
  end
endmodule

// File: rtl/brl_track.sv
module brl_track import brl_pkg::*; #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit,
  input  logic [AW-1:0] hit_pc,
  input  logic [AW-1:0] hit_tgt,
  input  logic          pf_ready,
  input  logic          done,
  output logic          pf_valid,
  output logic          armed,
  output logic [AW-1:0] la_pc,
  output logic [AW-1:0] la_tgt
);
  la_e st;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= LA_IDLE;
      la_pc  <= '0;
      la_tgt <= '0;
    end else begin
      case (st)
        LA_IDLE: if (hit) begin
          st     <= LA_REQ;
          la_pc  <= hit_pc;
          la_tgt <= hit_tgt;
        end
        LA_REQ:  if (pf_ready) st <= LA_WAIT;
        LA_WAIT: if (done)     st <= LA_IDLE;
        default: st <= LA_IDLE;
      endcase
    end
  end

  assign pf_valid = (st == LA_REQ);
  assign armed    = (st == LA_WAIT);
endmodule

// File: rtl/brl_unit.sv
module brl_unit import brl_pkg::*; #(
  parameter int QD = 4,
  parameter int AW = 32,
  parameter int DW = 14,
  parameter int NF = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [QD-1:0]          q_vld,
  input  logic [QD-1:0]          q_br,
  input  logic [QD-1:0]          q_lnk,
  input  logic [QD*$clog2(NF)-1:0] q_fld,
  input  logic [QD*2-1:0]        q_tst,
  input  logic [QD-1:0]          q_sense,
  input  logic [QD*DW-1:0]       q_disp,
  input  logic [QD*AW-1:0]       q_pc,
  input  logic [NF-1:0]          cr_wr_en,
  input  logic [NF*FLD_W-1:0]    cr_wr_data,
  input  logic [NF-1:0]          cr_claim,
  output logic                   pf_valid,
  input  logic                   pf_ready,
  output logic [AW-1:0]          pf_addr,
  output logic                   rs_valid,
  output logic                   rs_taken,
  output logic                   redirect_valid,
  output logic [AW-1:0]          redirect_pc,
  output logic [AW-1:0]          lr_out,
  output logic [NF*FLD_W-1:0]    cr_out
);
  localparam int FSW = $clog2(NF);

  logic [NF-1:0]   pend;
  logic            hit;
  logic [AW-1:0]   hit_pc, hit_tgt;
  logic            armed;
  logic [AW-1:0]   la_pc, la_tgt;

  brl_crfile #(.NF(NF)) u_cr (
    .clk(clk), .rst_n(rst_n), .wr_en(cr_wr_en), .wr_data(cr_wr_data),
    .claim(cr_claim), .cr(cr_out), .pend(pend)
  );

  brl_scan #(.QD(QD), .AW(AW), .DW(DW)) u_scan (
    .q_vld(q_vld), .q_br(q_br), .q_disp(q_disp), .q_pc(q_pc),
    .hit(hit), .hit_pc(hit_pc), .hit_tgt(hit_tgt)
  );

  brl_track #(.AW(AW)) u_trk (
    .clk(clk), .rst_n(rst_n), .hit(hit), .hit_pc(hit_pc), .hit_tgt(hit_tgt),
    .pf_ready(pf_ready), .done(rs_valid), .pf_valid(pf_valid), .armed(armed),
    .la_pc(la_pc), .la_tgt(la_tgt)
  );

  assign pf_addr = la_tgt;

  // head-of-queue resolution
  logic [FSW-1:0]   h_fld;
  logic [FLD_W-1:0] h_field;
  logic             h_match;

  assign h_fld    = q_fld[FSW-1:0];
  assign h_field  = cr_out[h_fld*FLD_W +: FLD_W];
  assign h_match  = armed && (la_pc == q_pc[AW-1:0]);
  assign rs_valid = q_vld[0] && q_br[0] && h_match && !pend[h_fld];
  assign rs_taken = rs_valid && (tst_bit(h_field, q_tst[1:0]) == q_sense[0]);

  assign redirect_valid = rs_taken;
  assign redirect_pc    = la_tgt;

  always_ff @(posedge clk) begin
    if (!rst_n)                   lr_out <= '0;
    else if (rs_taken && q_lnk[0]) lr_out <= q_pc[AW-1:0] + AW'(4);
  end

  // only the head's control bits steer resolution
  logic unused_tail;
  assign unused_tail = ^{q_lnk[QD-1:1], q_fld[QD*FSW-1:FSW], q_tst[QD*2-1:2], q_sense[QD-1:1]};
endmodule

// File: rtl/brl_check.sv
module brl_check #(
  parameter int QD = 4,
  parameter int AW = 32,
  parameter int NF = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [QD-1:0]          q_lnk,
  input logic [QD*$clog2(NF)-1:0] q_fld,
  input logic [QD*AW-1:0]       q_pc,
  input logic [NF-1:0]          cr_wr_en,
  input logic [NF*4-1:0]        cr_wr_data,
  input logic                   pf_valid,
  input logic                   pf_ready,
  input logic [AW-1:0]          pf_addr,
  input logic                   rs_valid,
  input logic                   rs_taken,
  input logic                   redirect_valid,
  input logic [AW-1:0]          lr_out,
  input logic [NF*4-1:0]        cr_out,
  input logic [NF-1:0]          pend
);
  localparam int FSW = $clog2(NF);

  p_cr_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cr_wr_en == '0) |=> $stable(cr_out));

  for (genvar i = 0; i < NF; i++) begin : g_w
    p_fld_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
      cr_wr_en[i] |=> (cr_out[i*4 +: 4] == $past(cr_wr_data[i*4 +: 4])));
  end

  p_pf_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && !pf_ready) |=> (pf_valid && $stable(pf_addr)));

  p_rs_after_pf_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid |-> !pf_valid);

  p_redirect_r5: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> (rs_valid && rs_taken));

  p_pend_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid |-> !pend[q_fld[FSW-1:0]]);

  p_link_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_taken && q_lnk[0]) |=> (lr_out == $past(q_pc[AW-1:0]) + AW'(4)));

  p_lr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rs_taken && q_lnk[0]) |=> $stable(lr_out));
endmodule

bind brl_unit brl_check #(.QD(QD), .AW(AW), .NF(NF)) u_chk (
  .clk(clk), .rst_n(rst_n), .q_lnk(q_lnk), .q_fld(q_fld), .q_pc(q_pc),
  .cr_wr_en(cr_wr_en), .cr_wr_data(cr_wr_data), .pf_valid(pf_valid),
  .pf_ready(pf_ready), .pf_addr(pf_addr), .rs_valid(rs_valid),
  .rs_taken(rs_taken), .redirect_valid(redirect_valid), .lr_out(lr_out),
  .cr_out(cr_out), .pend(pend)
);

// File: tb/tb_brl_unit.sv
module tb_brl_unit;
  localparam int QD = 4;
  localparam int AW = 32;
  localparam int DW = 14;
  localparam int NF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [QD-1:0]    q_vld = '0, q_br = '0, q_lnk = '0, q_sense = '0;
  logic [QD*3-1:0]  q_fld = '0;
  logic [QD*2-1:0]  q_tst = '0;
  logic [QD*DW-1:0] q_disp = '0;
  logic [QD*AW-1:0] q_pc = '0;
  logic [NF-1:0]    cr_wr_en = '0, cr_claim = '0;
  logic [NF*4-1:0]  cr_wr_data = '0;
  logic             pf_ready = 1'b1;
  logic             pf_valid, rs_valid, rs_taken, redirect_valid;
  logic [AW-1:0]    pf_addr, redirect_pc, lr_out;
  logic [NF*4-1:0]  cr_out;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic [NF*4-1:0] cr_model = '0;
  logic [AW-1:0]   lr_model = '0;

  always #2 clk = ~clk;

  brl_unit #(.QD(QD), .AW(AW), .DW(DW), .NF(NF)) dut (.*);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_q();
    q_vld = '0; q_br = '0; q_lnk = '0; q_sense = '0;
    q_fld = '0; q_tst = '0; q_disp = '0; q_pc = '0;
  endtask

  task automatic put_br(input int idx, input logic [AW-1:0] pc, input logic [DW-1:0] d,
                        input logic [2:0] f, input logic [1:0] code, input logic sense,
                        input logic lnk);
    q_vld[idx] = 1'b1; q_br[idx] = 1'b1; q_lnk[idx] = lnk; q_sense[idx] = sense;
    q_fld[idx*3 +: 3] = f; q_tst[idx*2 +: 2] = code;
    q_disp[idx*DW +: DW] = d; q_pc[idx*AW +: AW] = pc;
  endtask

  function automatic logic [AW-1:0] tgt_of(input logic [AW-1:0] pc, input logic [DW-1:0] d);
    return pc + AW'($signed(d)) * 4;
  endfunction

  // {field, nibble (neg,pos,zero,so), test code, sense, expected taken}
  localparam logic [10:0] VEC [8] = '{
    {3'd0, 4'b0100, 2'd0, 1'b0, 1'b1},
    {3'd1, 4'b1000, 2'd0, 1'b0, 1'b0},
    {3'd2, 4'b0010, 2'd2, 1'b1, 1'b1},
    {3'd3, 4'b0000, 2'd2, 1'b1, 1'b0},
    {3'd4, 4'b0001, 2'd3, 1'b1, 1'b1},
    {3'd5, 4'b0100, 2'd1, 1'b1, 1'b1},
    {3'd6, 4'b1111, 2'd1, 1'b0, 1'b0},
    {3'd7, 4'b0000, 2'd3, 1'b0, 1'b1}
  };

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 cr reset", AW'(cr_out), '0);
    chk("R10 lr reset", lr_out, '0);
    chk("R10 pf_valid reset", AW'(pf_valid), 0);
    chk("R10 rs_valid reset", AW'(rs_valid), 0);

    // table walk: condition test, target, link per vector
    for (int v = 0; v < 8; v++) begin
      automatic logic [2:0]    f    = VEC[v][10:8];
      automatic logic [3:0]    nib  = VEC[v][7:4];
      automatic logic [1:0]    code = VEC[v][3:2];
      automatic logic          sns  = VEC[v][1];
      automatic logic          ext  = VEC[v][0];
      automatic logic [DW-1:0] d    = (v % 2 == 1) ? 14'h3ffd : DW'(v + 5);
      automatic logic [AW-1:0] pc   = 32'h1000 + AW'(v) * 32;
      cr_wr_en = NF'(1) << f;
      cr_wr_data = '0;
      cr_wr_data[f*4 +: 4] = nib;
      put_br(0, pc, d, f, code, sns, 1'b1);
      tick();
      cr_wr_en = '0;
      cr_model[f*4 +: 4] = nib;
      chk("R1 field write", AW'(cr_out), AW'(cr_model));
      chk("R3 prefetch valid", AW'(pf_valid), 1);
      chk("R3 prefetch target", pf_addr, tgt_of(pc, d));
      tick();
      chk("R5 resolve", AW'(rs_valid), 1);
      chk(ext ? "R2 taken" : "R7 not taken redirect", AW'(redirect_valid), AW'(ext));
      if (ext) chk("R5 redirect pc", redirect_pc, tgt_of(pc, d));
      tick();
      clear_q();
      if (ext) lr_model = pc + 4;
      chk("R8 link", lr_out, lr_model);
    end

    // R1: several fields in one cycle, others untouched
    cr_wr_en = 8'b1010_0101;
    cr_wr_data = 32'h9876_5432;
    tick();
    cr_wr_en = '0;
    for (int i = 0; i < NF; i++)
      if (i == 0 || i == 2 || i == 5 || i == 7) cr_model[i*4 +: 4] = cr_wr_data[i*4 +: 4];
    chk("R1 multi-field write", AW'(cr_out), AW'(cr_model));

    // R6: pending writer holds the branch; claim beats a same-cycle write
    cr_claim = 8'b0000_1000;
    put_br(0, 32'h2000, 14'h0004, 3'd3, 2'd0, 1'b0, 1'b0);
    tick();
    cr_claim = '0;
    tick();
    tick();
    chk("R6 pending blocks", AW'(rs_valid), 0);
    cr_wr_en = 8'b0000_1000; cr_claim = 8'b0000_1000; cr_wr_data = '0;
    tick();
    cr_wr_en = '0; cr_claim = '0;
    cr_model[12 +: 4] = 4'b0000;
    tick();
    chk("R6 claim over write", AW'(rs_valid), 0);
    cr_wr_en = 8'b0000_1000;
    tick();
    cr_wr_en = '0;
    chk("R6 write releases", AW'(rs_valid), 1);
    chk("R6 taken after release", AW'(redirect_valid), 1);
    chk("R5 redirect pc pending", redirect_pc, 32'h2010);
    tick();
    clear_q();
    chk("R8 no link kept", lr_out, lr_model);

    // R4: back-pressure on prefetch port (field 0 holds 0010: neg clear)
    pf_ready = 1'b0;
    put_br(0, 32'h3000, 14'h0010, 3'd0, 2'd0, 1'b0, 1'b1);
    tick();
    chk("R4 request up", AW'(pf_valid), 1);
    tick();
    tick();
    chk("R4 valid held", AW'(pf_valid), 1);
    chk("R4 addr held", pf_addr, 32'h3040);
    chk("R5 waits for accept", AW'(rs_valid), 0);
    pf_ready = 1'b1;
    tick();
    chk("R5 resolve after accept", AW'(rs_valid), 1);
    chk("R5 taken plus", AW'(redirect_valid), 1);
    tick();
    clear_q();
    chk("R8 link after stall", lr_out, 32'h3004);
    lr_model = 32'h3004;

    // R9: oldest branch only. field 0 = 0010, field 1 = 1000 (neg set)
    q_vld[0] = 1'b1; q_pc[0 +: AW] = 32'h4000;
    put_br(1, 32'h4004, 14'h0008, 3'd0, 2'd2, 1'b1, 1'b0);
    put_br(2, 32'h4008, 14'h3fff, 3'd1, 2'd0, 1'b1, 1'b1);
    tick();
    chk("R9 oldest target", pf_addr, 32'h4024);
    tick();
    chk("R9 no second request", AW'(pf_valid), 0);
    chk("R5 head not branch", AW'(rs_valid), 0);
    clear_q();
    put_br(0, 32'h4004, 14'h0008, 3'd0, 2'd2, 1'b1, 1'b0);
    put_br(1, 32'h4008, 14'h3fff, 3'd1, 2'd0, 1'b1, 1'b1);
    #1;
    chk("R5 zero-bubble redirect", redirect_pc, 32'h4024);
    chk("R9 head resolves", AW'(rs_valid & rs_taken), 1);
    tick();
    clear_q();
    put_br(0, 32'h4008, 14'h3fff, 3'd1, 2'd0, 1'b1, 1'b1);
    tick();
    chk("R9 next branch prefetched", pf_addr, 32'h4004);
    tick();
    chk("R2 neg set taken", AW'(redirect_valid), 1);
    tick();
    clear_q();
    chk("R8 second link", lr_out, 32'h400c);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule